// File: doc/BRIEF.md
# Bus Target Latency Timeout Controller

This block measures how long a bus target takes to deliver data for a request that was forwarded to internal logic. A start pulse opens a transaction. The block then counts clock cycles against a latency limit. The first data phase uses the initial limit. Each later data phase uses the subsequent limit, and that limit is reloaded whenever a data phase completes. When a limit runs out before data is ready, the block ends the transaction with a one-cycle response pulse. The pulse is either a retry or a target abort, chosen by a separate policy bit for reads and for writes. A retry-now control answers at once with a retry instead of waiting.

The initial limit comes from a 4-bit code with a non-linear meaning. In conventional mode, code 0 means 16 cycles. Codes 1 to 7 turn the initial counter off. Codes 8 to 15 mean that many cycles. In the extended (PCI-X) mode the code is ignored and the limit is 8 cycles. The subsequent limit has only one supported code, 0, which means 8 cycles. Any other subsequent code also gives 8 cycles, and it sets a sticky configuration-error flag.

Top module: `tgt_lat_watchdog`

## Requirements
- R1: After synchronous reset, `rsp_retry`, `rsp_abort`, `busy` and `cfg_err` are all 0.
- R2: In conventional mode (`cfg_pcix_mode`=0) with initial code 0, a response pulse appears 16 cycles after the start pulse is sampled if no data phase completes.
- R3: In conventional mode, initial codes 1 to 7 disable the initial timeout: the transaction stays busy with no response until data is ready.
- R4: In conventional mode, initial codes 8 to 15 give an initial limit equal to the code value in cycles.
- R5: With `cfg_pcix_mode`=1, the initial limit is 8 cycles whatever the initial code.
- R6: After a data phase completes without `data_last`, the subsequent limit of 8 cycles applies, and it is reloaded by every completed data phase.
- R7: On a read timeout (`req_is_write`=0 at start), the response is an abort if `cfg_rd_abort_en`=1 and a retry otherwise.
- R8: On a write timeout (`req_is_write`=1 at start), the response is an abort if `cfg_wr_abort_en`=1 and a retry otherwise.
- R9: While a transaction is busy, `cfg_retry_now`=1 with data not ready produces a retry pulse in the next cycle.
- R10: A response lasts exactly one cycle, retry and abort are never high together, and the block is idle (`busy`=0) while the pulse is high.
- R11: No response follows a cycle in which `data_ready` is high, even if that cycle would have reached the limit.
- R12: A nonzero subsequent code is treated as 8 cycles and sets `cfg_err`, which stays 1 until reset.
- R13: A start pulse while busy is ignored and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Opens a transaction (one-cycle pulse) |
| req_is_write | input | 1 | Request type, sampled with req_start: 1 write, 0 read |
| data_ready | input | 1 | A data phase completes this cycle |
| data_last | input | 1 | With data_ready, the phase ends the transaction |
| cfg_pcix_mode | input | 1 | 1 selects the extended bus mode with a fixed initial limit |
| cfg_init_code | input | 4 | Initial-latency code |
| cfg_subseq_code | input | 3 | Subsequent-latency code (only 0 supported) |
| cfg_rd_abort_en | input | 1 | Read timeouts answer with abort |
| cfg_wr_abort_en | input | 1 | Write timeouts answer with abort |
| cfg_retry_now | input | 1 | Answer with an immediate retry |
| busy | output | 1 | A transaction is being timed |
| rsp_retry | output | 1 | One-cycle retry response |
| rsp_abort | output | 1 | One-cycle target-abort response |
| cfg_err | output | 1 | Sticky flag for an unsupported subsequent code |

## Verification
The colliding pair is data readiness and limit expiry. The bench raises `data_ready` in exactly the cycle whose edge would complete the limit count, and requires that no response follows and that the transaction closes normally. A scoreboard holds the cycle and kind of every expected response. Any pulse that is not queued, or that comes at another cycle, counts as a failure. The same scoreboard also catches a second start pulse during a transaction: if that pulse restarted the count, the response would land late.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_NEXT   = 2'd2
  } tlw_phase_e;

  function automatic int unsigned tlw_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tlw_limit_sel.sv
module tlw_limit_sel
  import tlw_pkg::*;
#(
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned INIT_CODE_W = 4,
  parameter int unsigned SUB_CODE_W  = 3,
  parameter int unsigned ZERO_CODE_LIM = 16,
  parameter int unsigned OFF_CODE_HI = 7,
  parameter int unsigned PCIX_LIM    = 8,
  parameter int unsigned SUBSEQ_LIM  = 8
) (
  input  tlw_phase_e             phase,
  input  logic                   pcix_mode,
  input  logic [INIT_CODE_W-1:0] init_code,
  input  logic [SUB_CODE_W-1:0]  subseq_code,
  output logic [CNT_W-1:0]       limit,
  output logic                   limit_en,
  output logic                   subseq_bad
);

  localparam logic [CNT_W-1:0] ZERO_L = CNT_W'(ZERO_CODE_LIM);
  localparam logic [CNT_W-1:0] PCIX_L = CNT_W'(PCIX_LIM);
  localparam logic [CNT_W-1:0] SUB_L  = CNT_W'(SUBSEQ_LIM);
  localparam logic [INIT_CODE_W-1:0] OFF_HI = INIT_CODE_W'(OFF_CODE_HI);

  logic [CNT_W-1:0] init_lim;
  logic             init_en;

  // Initial limit decode: code 0 fixed, low band off, upper band literal.
  always_comb begin
    init_lim = CNT_W'(init_code);
    init_en  = 1'b1;
    if (pcix_mode) begin
      init_lim = PCIX_L;
    end else if (init_code == '0) begin
      init_lim = ZERO_L;
    end else if (init_code <= OFF_HI) begin
      init_en  = 1'b0;
    end
  end

  // Only the zero code is supported; every code maps to the same limit.
  assign subseq_bad = (subseq_code != '0);

  always_comb begin
    limit    = SUB_L;
    limit_en = 1'b1;
    case (phase)
      PH_FIRST: begin
        limit    = init_lim;
        limit_en = init_en;
      end
      PH_NEXT: begin
        limit    = SUB_L;
        limit_en = 1'b1;
      end
      default: begin
        limit    = SUB_L;
        limit_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/tlw_lat_counter.sv
module tlw_lat_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  input  logic             limit_en,
  output logic             expire
);

  logic [CNT_W-1:0] waited;
  logic [CNT_W:0]   next_w;

  assign next_w = {1'b0, waited} + {{CNT_W{1'b0}}, 1'b1};
  assign expire = inc && limit_en && (next_w == {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      waited <= '0;
    end else if (inc && limit_en) begin
      waited <= next_w[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/tlw_phase_fsm.sv
module tlw_phase_fsm
  import tlw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_start,
  input  logic       req_is_write,
  input  logic       data_ready,
  input  logic       data_last,
  input  logic       retry_now,
  input  logic       expire,
  input  logic       rd_abort_en,
  input  logic       wr_abort_en,
  output tlw_phase_e phase,
  output logic       busy,
  output logic       cnt_clr,
  output logic       cnt_inc,
  output logic       rsp_retry,
  output logic       rsp_abort
);

  logic active;
  logic wr_q;
  logic abort_sel;

  assign active    = (phase != PH_IDLE);
  assign busy      = active;
  assign abort_sel = wr_q ? wr_abort_en : rd_abort_en;
  assign cnt_inc   = active && !data_ready && !retry_now;
  assign cnt_clr   = !active || data_ready || retry_now || expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      wr_q      <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_abort <= 1'b0;
    end else begin
      rsp_retry <= 1'b0;
      rsp_abort <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req_start) begin
            phase <= PH_FIRST;
            wr_q  <= req_is_write;
          end
        end
        default: begin
          if (data_ready) begin
            phase <= data_last ? PH_IDLE : PH_NEXT;
          end else if (retry_now) begin
            rsp_retry <= 1'b1;
            phase     <= PH_IDLE;
          end else if (expire) begin
            rsp_abort <= abort_sel;
            rsp_retry <= !abort_sel;
            phase     <= PH_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/tgt_lat_watchdog.sv
module tgt_lat_watchdog
  import tlw_pkg::*;
#(
  parameter int unsigned INIT_CODE_W   = 4,
  parameter int unsigned SUB_CODE_W    = 3,
  parameter int unsigned ZERO_CODE_LIM = 16,
  parameter int unsigned OFF_CODE_HI   = 7,
  parameter int unsigned PCIX_LIM      = 8,
  parameter int unsigned SUBSEQ_LIM    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_start,
  input  logic                   req_is_write,
  input  logic                   data_ready,
  input  logic                   data_last,
  input  logic                   cfg_pcix_mode,
  input  logic [INIT_CODE_W-1:0] cfg_init_code,
  input  logic [SUB_CODE_W-1:0]  cfg_subseq_code,
  input  logic                   cfg_rd_abort_en,
  input  logic                   cfg_wr_abort_en,
  input  logic                   cfg_retry_now,
  output logic                   busy,
  output logic                   rsp_retry,
  output logic                   rsp_abort,
  output logic                   cfg_err
);

  localparam int unsigned CODE_MAX = (1 << INIT_CODE_W) - 1;
  localparam int unsigned MAX_LIM  =
    tlw_max(tlw_max(ZERO_CODE_LIM, CODE_MAX), tlw_max(PCIX_LIM, SUBSEQ_LIM));
  localparam int unsigned CNT_W    = $clog2(MAX_LIM + 1);

  tlw_phase_e       phase;
  logic [CNT_W-1:0] limit;
  logic             limit_en;
  logic             subseq_bad;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             expire;

  tlw_limit_sel #(
    .CNT_W        (CNT_W),
    .INIT_CODE_W  (INIT_CODE_W),
    .SUB_CODE_W   (SUB_CODE_W),
    .ZERO_CODE_LIM(ZERO_CODE_LIM),
    .OFF_CODE_HI  (OFF_CODE_HI),
    .PCIX_LIM     (PCIX_LIM),
    .SUBSEQ_LIM   (SUBSEQ_LIM)
  ) u_limit (
    .phase      (phase),
    .pcix_mode  (cfg_pcix_mode),
    .init_code  (cfg_init_code),
    .subseq_code(cfg_subseq_code),
    .limit      (limit),
    .limit_en   (limit_en),
    .subseq_bad (subseq_bad)
  );

  tlw_lat_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .limit   (limit),
    .limit_en(limit_en),
    .expire  (expire)
  );

  tlw_phase_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_start   (req_start),
    .req_is_write(req_is_write),
    .data_ready  (data_ready),
    .data_last   (data_last),
    .retry_now   (cfg_retry_now),
    .expire      (expire),
    .rd_abort_en (cfg_rd_abort_en),
    .wr_abort_en (cfg_wr_abort_en),
    .phase       (phase),
    .busy        (busy),
    .cnt_clr     (cnt_clr),
    .cnt_inc     (cnt_inc),
    .rsp_retry   (rsp_retry),
    .rsp_abort   (rsp_abort)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err <= 1'b0;
    end else if (subseq_bad) begin
      cfg_err <= 1'b1;
    end
  end

endmodule

// File: rtl/tlw_checker.sv
module tlw_checker #(
  parameter int unsigned SUB_CODE_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  data_ready,
  input logic                  cfg_retry_now,
  input logic [SUB_CODE_W-1:0] cfg_subseq_code,
  input logic                  busy,
  input logic                  rsp_retry,
  input logic                  rsp_abort,
  input logic                  cfg_err
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!busy && !rsp_retry && !rsp_abort && !cfg_err));

  assert_rsp_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(rsp_retry && rsp_abort));

  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_retry || rsp_abort) |=> !(rsp_retry || rsp_abort));

  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_retry || rsp_abort) |-> !busy);

  assert_ready_no_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    data_ready |=> !(rsp_retry || rsp_abort));

  assert_retry_now_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_retry_now && !data_ready) |=> (rsp_retry && !rsp_abort));

  assert_err_set_R12: assert property (@(posedge clk) disable iff (rst)
    (cfg_subseq_code != '0) |=> cfg_err);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

endmodule

bind tgt_lat_watchdog tlw_checker #(
  .SUB_CODE_W(SUB_CODE_W)
) u_tlw_chk (
  .clk            (clk),
  .rst            (rst),
  .data_ready     (data_ready),
  .cfg_retry_now  (cfg_retry_now),
  .cfg_subseq_code(cfg_subseq_code),
  .busy           (busy),
  .rsp_retry      (rsp_retry),
  .rsp_abort      (rsp_abort),
  .cfg_err        (cfg_err)
);

// File: tb/tgt_lat_watchdog_bench.sv
module tgt_lat_watchdog_bench;

  typedef struct {
    bit    is_abort;
    int    at;
    string req;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_start = 1'b0;
  logic       req_is_write = 1'b0;
  logic       data_ready = 1'b0;
  logic       data_last = 1'b0;
  logic       cfg_pcix_mode = 1'b0;
  logic [3:0] cfg_init_code = 4'd0;
  logic [2:0] cfg_subseq_code = 3'd0;
  logic       cfg_rd_abort_en = 1'b0;
  logic       cfg_wr_abort_en = 1'b0;
  logic       cfg_retry_now = 1'b0;
  logic       busy;
  logic       rsp_retry;
  logic       rsp_abort;
  logic       cfg_err;

  int        cyc = 0;
  int        checks = 0;
  int        errors = 0;
  bit        done = 1'b0;
  exp_item_t sb_q[$];

  tgt_lat_watchdog u_tgt_lat_watchdog (
    .clk            (clk),
    .rst            (rst),
    .req_start      (req_start),
    .req_is_write   (req_is_write),
    .data_ready     (data_ready),
    .data_last      (data_last),
    .cfg_pcix_mode  (cfg_pcix_mode),
    .cfg_init_code  (cfg_init_code),
    .cfg_subseq_code(cfg_subseq_code),
    .cfg_rd_abort_en(cfg_rd_abort_en),
    .cfg_wr_abort_en(cfg_wr_abort_en),
    .cfg_retry_now  (cfg_retry_now),
    .busy           (busy),
    .rsp_retry      (rsp_retry),
    .rsp_abort      (rsp_abort),
    .cfg_err        (cfg_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Expected policy per requirement R7 / R8.
  function automatic bit exp_abort(input bit wr);
    return wr ? cfg_wr_abort_en : cfg_rd_abort_en;
  endfunction

  task automatic push(input bit ab, input int at, input string req);
    exp_item_t it;
    it.is_abort = ab;
    it.at = at;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: every response must match the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && (rsp_retry || rsp_abort)) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "unexpected response", {30'd0, rsp_abort, rsp_retry}, 0);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(rsp_abort == it.is_abort && rsp_retry == !it.is_abort, it.req,
              int'(rsp_abort), int'(it.is_abort));
        check(cyc == it.at, it.req, cyc, it.at);
        check(!busy && !(rsp_abort && rsp_retry), "R10", int'(busy), 0);
      end
    end
  end

  task automatic start_txn(input bit wr, output int s);
    @(negedge clk);
    s = cyc;
    req_start = 1'b1;
    req_is_write = wr;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic data_at(input int n, input bit last);
    while (cyc < n) @(negedge clk);
    data_ready = 1'b1;
    data_last = last;
    @(negedge clk);
    data_ready = 1'b0;
    data_last = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 60 && sb_q.size() != 0; i++) @(negedge clk);
    check(sb_q.size() == 0, req, sb_q.size(), 0);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, req, int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!busy && !rsp_retry && !rsp_abort && !cfg_err, "R1",
          {28'd0, busy, rsp_retry, rsp_abort, cfg_err}, 0);

    // R2 / R7: code 0, read, retry policy
    start_txn(1'b0, s);
    push(exp_abort(1'b0), s + 17, "R2 R7");
    drain("R2");

    // R4 / R7: code 10, read, abort policy
    cfg_init_code = 4'd10; cfg_rd_abort_en = 1'b1;
    start_txn(1'b0, s);
    push(exp_abort(1'b0), s + 11, "R4 R7");
    drain("R4");

    // R4 / R8: code 15, write, abort policy
    cfg_init_code = 4'd15; cfg_wr_abort_en = 1'b1;
    start_txn(1'b1, s);
    push(exp_abort(1'b1), s + 16, "R4 R8");
    drain("R4");

    // R8: code 8, write with write-abort off while read-abort on
    cfg_init_code = 4'd8; cfg_wr_abort_en = 1'b0;
    start_txn(1'b1, s);
    push(exp_abort(1'b1), s + 9, "R8");
    drain("R8");
    cfg_rd_abort_en = 1'b0;

    // R5: extended mode ignores the code
    cfg_pcix_mode = 1'b1; cfg_init_code = 4'd0;
    start_txn(1'b0, s);
    push(1'b0, s + 9, "R5");
    drain("R5");
    cfg_init_code = 4'd3;
    start_txn(1'b0, s);
    push(1'b0, s + 9, "R5");
    drain("R5");
    cfg_pcix_mode = 1'b0;

    // R3 / R6: disabled initial counter, then subsequent limit
    cfg_init_code = 4'd5;
    start_txn(1'b0, s);
    repeat (30) @(negedge clk);
    check(busy == 1'b1, "R3", int'(busy), 1);
    d = cyc;
    data_at(d, 1'b0);
    push(1'b0, d + 9, "R6");
    drain("R6");

    // R6: subsequent limit reloads after each data phase
    cfg_init_code = 4'd0;
    start_txn(1'b0, s);
    data_at(s + 5, 1'b0);
    data_at(s + 11, 1'b0);
    push(1'b0, s + 20, "R6");
    drain("R6");

    // R9: retry-now answers at once
    cfg_retry_now = 1'b1;
    start_txn(1'b1, s);
    push(1'b0, s + 2, "R9");
    drain("R9");
    cfg_retry_now = 1'b0;

    // R11: data ready on the limit edge suppresses the response
    cfg_init_code = 4'd8; cfg_rd_abort_en = 1'b1;
    start_txn(1'b0, s);
    data_at(s + 8, 1'b1);
    repeat (20) @(negedge clk);
    check(busy == 1'b0 && sb_q.size() == 0, "R11", int'(busy), 0);
    cfg_rd_abort_en = 1'b0;

    // R13: a second start pulse during a transaction is ignored
    cfg_init_code = 4'd0;
    start_txn(1'b0, s);
    while (cyc < s + 4) @(negedge clk);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    push(1'b0, s + 17, "R13");
    drain("R13");

    // R12: unsupported subsequent code behaves as 8 and sets sticky error
    check(cfg_err == 1'b0, "R12", int'(cfg_err), 0);
    cfg_subseq_code = 3'd3;
    start_txn(1'b0, s);
    check(cfg_err == 1'b1, "R12", int'(cfg_err), 1);
    data_at(s + 3, 1'b0);
    push(1'b0, s + 12, "R12");
    drain("R12");
    cfg_subseq_code = 3'd0;
    repeat (3) @(negedge clk);
    check(cfg_err == 1'b1, "R12", int'(cfg_err), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule